// File: doc/BRIEF.md
# Sequential Complex Multiplier

This block forms the product of two complex operands, each given as signed real and imaginary parts. It has a single real multiplier, one adder/subtractor and two partial-product registers. A small step controller drives them. One operation takes a fixed schedule of five steps. The real result is formed from the first two partial products. The imaginary result is formed from the next two.

A one-cycle start pulse in idle captures all four operand parts into input registers and launches the schedule. While the schedule runs, start is ignored. One cycle after the last step, a one-cycle done pulse marks both results as valid. Both results are widened to 2W+1 bits, so no product or sum can overflow. Each result holds its value until the next operation overwrites it. In the done cycle the controller is already idle, so a new start there is accepted at once.

Top module: `cplx_seq_mul`

## Requirements
- R1: While rst_ni is low, done_o, p_re_o and p_im_o are all zero, and the controller is idle.
- R2: After an operation, p_re_o equals a_re·b_re − a_im·b_im as an exact signed value.
- R3: After an operation, p_im_o equals a_re·b_im + a_im·b_re as an exact signed value.
- R4: Let the edge that samples start in idle be edge 0. done_o is high for exactly one cycle, following rising edge 5, and is low after edges 1 to 4.
- R5: Operand parts are sampled only on the edge that accepts start. Input changes after that edge do not affect the result.
- R6: A start that arrives while the schedule runs (steps 1 to 5) is ignored. Results reflect the first operation only, and only one done pulse is produced.
- R7: p_re_o takes its new value after edge 3 and p_im_o after edge 5. Each output holds its value at all other times, including while idle.
- R8: A start asserted in the done cycle is accepted. Back-to-back operations then run every six cycles with correct results.
- R9: The most negative operand value, −2^(W−1), gives exact results in every combination, for example (−8·−8 + −8·7) in a W=4 build.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start strobe, accepted only in idle |
| a_re_i | input | W | Real part of operand A, signed |
| a_im_i | input | W | Imaginary part of operand A, signed |
| b_re_i | input | W | Real part of operand B, signed |
| b_im_i | input | W | Imaginary part of operand B, signed |
| done_o | output | 1 | One-cycle pulse when both results are valid |
| p_re_o | output | 2W+1 | Real part of the product, signed |
| p_im_o | output | 2W+1 | Imaginary part of the product, signed |

## Verification
The done pulse of one operation falls in the same cycle as the acceptance of the next start. That cycle must also leave the finished results intact until edge 3 of the new operation. The bench provokes this collision by running a near-exhaustive sweep of a W=4 build back to back: each new start is asserted in the very cycle that done is observed. In that cycle the bench judges the previous results against arithmetic products. One cycle later it checks that done has dropped. A separate staged test samples between edges to confirm that the real and imaginary outputs change only after edges 3 and 5 respectively.

// File: rtl/cplx_seq_pkg.sv
package cplx_seq_pkg;
  localparam int unsigned NUM_PARTS = 4;
  localparam int unsigned IDX_A_RE = 0;
  localparam int unsigned IDX_A_IM = 1;
  localparam int unsigned IDX_B_RE = 2;
  localparam int unsigned IDX_B_IM = 3;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_RR   = 3'd1,
    ST_II   = 3'd2,
    ST_RI   = 3'd3,
    ST_IR   = 3'd4,
    ST_SUM  = 3'd5
  } step_e;

  typedef struct packed {
    logic load;
    logic a_sel;   // 0: real, 1: imag
    logic b_sel;   // 0: real, 1: imag
    logic pp1_en;
    logic pp2_en;
    logic pr_en;
    logic pi_en;
    logic sub;
  } ctl_t;
endpackage

// File: rtl/cplx_seq_opreg.sv
module cplx_seq_opreg #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (en_i) q_o <= d_i;
  end

  assert_opnd_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(q_o));
endmodule

// File: rtl/cplx_seq_ctrl.sv
module cplx_seq_ctrl
  import cplx_seq_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output ctl_t ctl_o,
  output logic done_o
);
  step_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (start_i) st_d = ST_RR;
      ST_RR:   st_d = ST_II;
      ST_II:   st_d = ST_RI;
      ST_RI:   st_d = ST_IR;
      ST_IR:   st_d = ST_SUM;
      ST_SUM:  st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      done_o <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_o <= (st_q == ST_SUM);
    end
  end

  always_comb begin
    ctl_o      = '0;
    ctl_o.load = (st_q == ST_IDLE) && start_i;
    unique case (st_q)
      ST_RR: ctl_o.pp1_en = 1'b1;
      ST_II: begin
        ctl_o.a_sel  = 1'b1;
        ctl_o.b_sel  = 1'b1;
        ctl_o.pp2_en = 1'b1;
      end
      ST_RI: begin
        // real result and next partial product load in the same step
        ctl_o.b_sel  = 1'b1;
        ctl_o.pp1_en = 1'b1;
        ctl_o.pr_en  = 1'b1;
        ctl_o.sub    = 1'b1;
      end
      ST_IR: begin
        ctl_o.a_sel  = 1'b1;
        ctl_o.pp2_en = 1'b1;
      end
      ST_SUM: ctl_o.pi_en = 1'b1;
      default: ;
    endcase
  end

  assert_done_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_busy_ignores_start_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_RR) |=> (st_q == ST_II));
  assert_sum_returns_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_SUM) |=> (st_q == ST_IDLE));
endmodule

// File: rtl/cplx_seq_dp.sv
module cplx_seq_dp
  import cplx_seq_pkg::*;
#(
  parameter  int unsigned W  = 16,
  localparam int unsigned RW = 2 * W + 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  ctl_t                   ctl_i,
  input  logic [NUM_PARTS*W-1:0] opnd_i,
  output logic signed [RW-1:0]   p_re_o,
  output logic signed [RW-1:0]   p_im_o
);
  logic [W-1:0] opnd_q [NUM_PARTS];

  for (genvar g = 0; g < NUM_PARTS; g++) begin : g_opnd
    cplx_seq_opreg #(.W(W)) u_reg (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .en_i  (ctl_i.load),
      .d_i   (opnd_i[g*W +: W]),
      .q_o   (opnd_q[g])
    );
  end

  logic signed [W-1:0]    mul_a, mul_b;
  logic signed [2*W-1:0]  prod;
  logic signed [RW-1:0]   prod_x, pp1_q, pp2_q, comb_res;

  assign mul_a    = ctl_i.a_sel ? $signed(opnd_q[IDX_A_IM]) : $signed(opnd_q[IDX_A_RE]);
  assign mul_b    = ctl_i.b_sel ? $signed(opnd_q[IDX_B_IM]) : $signed(opnd_q[IDX_B_RE]);
  assign prod     = mul_a * mul_b;
  assign prod_x   = {prod[2*W-1], prod};
  assign comb_res = ctl_i.sub ? (pp1_q - pp2_q) : (pp1_q + pp2_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pp1_q  <= '0;
      pp2_q  <= '0;
      p_re_o <= '0;
      p_im_o <= '0;
    end else begin
      if (ctl_i.pp1_en) pp1_q  <= prod_x;
      if (ctl_i.pp2_en) pp2_q  <= prod_x;
      if (ctl_i.pr_en)  p_re_o <= comb_res;
      if (ctl_i.pi_en)  p_im_o <= comb_res;
    end
  end

  assert_pre_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctl_i.pr_en |=> $stable(p_re_o));
  assert_pim_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctl_i.pi_en |=> $stable(p_im_o));
endmodule

// File: rtl/cplx_seq_mul.sv
module cplx_seq_mul
  import cplx_seq_pkg::*;
#(
  parameter  int unsigned W  = 16,
  localparam int unsigned RW = 2 * W + 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic [W-1:0]         a_re_i,
  input  logic [W-1:0]         a_im_i,
  input  logic [W-1:0]         b_re_i,
  input  logic [W-1:0]         b_im_i,
  output logic                 done_o,
  output logic signed [RW-1:0] p_re_o,
  output logic signed [RW-1:0] p_im_o
);
  ctl_t ctl;

  cplx_seq_ctrl u_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_i),
    .ctl_o  (ctl),
    .done_o (done_o)
  );

  cplx_seq_dp #(.W(W)) u_dp (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .ctl_i (ctl),
    .opnd_i({b_im_i, b_re_i, a_im_i, a_re_i}),
    .p_re_o(p_re_o),
    .p_im_o(p_im_o)
  );

  assert_done_after_pim_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(ctl.pi_en));
  assert_result_en_excl_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ctl.pr_en, ctl.pi_en}));
  assert_start_enters_step1_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl.load |=> (ctl.pp1_en && !ctl.pp2_en && !ctl.pr_en));
endmodule

// File: tb/cplx_seq_mul_bench.sv
module cplx_seq_mul_bench;
  localparam int CLK_PERIOD = 10;
  localparam int W  = 4;
  localparam int RW = 2 * W + 1;

  logic clk = 1'b0, rst_ni = 1'b0, start = 1'b0;
  logic [W-1:0] a_re = '0, a_im = '0, b_re = '0, b_im = '0;
  logic done;
  logic signed [RW-1:0] p_re, p_im;
  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cplx_seq_mul #(.W(W)) u_cplx_seq_mul (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start),
    .a_re_i(a_re), .a_im_i(a_im), .b_re_i(b_re), .b_im_i(b_im),
    .done_o(done), .p_re_o(p_re), .p_im_o(p_im)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic drive(input int ar, input int ai, input int br, input int bi);
    a_re = W'(ar); a_im = W'(ai); b_re = W'(br); b_im = W'(bi);
    start = 1'b1;
  endtask

  // called at a negedge in idle; returns at the negedge of the done cycle
  task automatic full_op(input int ar, input int ai, input int br, input int bi,
                         input bit scramble, input string tag);
    drive(ar, ai, br, bi);
    @(negedge clk);
    start = 1'b0;
    chk({tag, "/R4 done low after edge 1"}, int'(done), 0);
    if (scramble) begin
      a_re = W'(ar + 3); a_im = W'(ai - 5); b_re = W'(~br); b_im = W'(bi + 1);
    end
    repeat (4) @(negedge clk);
    chk({tag, "/R4 done low after edge 4"}, int'(done), 0);
    @(negedge clk);
    chk({tag, "/R4 done high after edge 5"}, int'(done), 1);
    chk({tag, "/R2 real"}, int'(p_re), ar * br - ai * bi);
    chk({tag, "/R3 imag"}, int'(p_im), ar * bi + ai * br);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R4 watchdog: actual 150000 cycles expected earlier finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin : main
    int sel [4];
    int old_r, old_i;
    sel = '{-8, -1, 0, 7};

    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 done in reset", int'(done), 0);
    chk("R1 p_re in reset", int'(p_re), 0);
    chk("R1 p_im in reset", int'(p_im), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 done idle after reset", int'(done), 0);

    // R9: extreme operands
    full_op(-8, -8, -8, -8, 1'b0, "R9");
    full_op(-8, -8, -8,  7, 1'b0, "R9");
    full_op( 7, -8,  7, -8, 1'b0, "R9");
    old_r = -15; old_i = -112;

    // R7: staged update of the two results
    drive(3, 2, -5, 6);
    @(negedge clk); start = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R7 p_re old after edge 2", int'(p_re), old_r);
    @(negedge clk);
    chk("R7 p_re new after edge 3", int'(p_re), -27);
    chk("R7 p_im old after edge 3", int'(p_im), old_i);
    @(negedge clk);
    chk("R7 p_im old after edge 4", int'(p_im), old_i);
    @(negedge clk);
    chk("R7 p_im new after edge 5", int'(p_im), 8);
    chk("R7 done with p_im", int'(done), 1);
    a_re = 4'd5; a_im = 4'd9; b_re = 4'd1; b_im = 4'd14;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      chk("R7 p_re held idle", int'(p_re), -27);
      chk("R7 p_im held idle", int'(p_im), 8);
      chk("R7 done low idle", int'(done), 0);
    end

    // R5: inputs changed right after sampling
    full_op(5, -3, 2, 4, 1'b1, "R5");
    @(negedge clk);

    // R6: start held through the busy steps with other operands
    drive(1, 2, 3, 4);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      a_re = W'(i - 4); a_im = W'(7 - i); b_re = W'(i); b_im = W'(-i);
      start = 1'b1;
    end
    @(negedge clk);
    start = 1'b0;
    chk("R6 done once", int'(done), 1);
    chk("R6 real from first op", int'(p_re), -5);
    chk("R6 imag from first op", int'(p_im), 10);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      chk("R6 no second done", int'(done), 0);
      chk("R6 p_re unchanged", int'(p_re), -5);
    end

    // R8: back-to-back sweep, each start in the previous done cycle
    for (int ar = -8; ar < 8; ar++)
      for (int br = -8; br < 8; br++)
        for (int i = 0; i < 4; i++)
          for (int j = 0; j < 4; j++)
            full_op(ar, sel[i], br, sel[j], 1'b0, "R8");
    @(negedge clk);
    chk("R8 done drops after last op", int'(done), 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule